// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast system clock into the bit rhythm of a CAN node. A prescaler cuts the clock into time quanta. Every bit is laid out as one synchronisation quantum, then a first segment, then a second segment. A strobe marks the sample point at the end of the first segment, and a second strobe marks the transmit point where a new bit begins. At the sample point the receive line is captured, either as a single value or as a majority of three quanta.

The generator follows the bus. While the frame logic reports the bus as idle, a recessive-to-dominant edge forces a hard synchronisation that restarts the bit. During a frame the same kind of edge moves the sample point. It lengthens the first segment or shortens the second by the measured phase error, but never by more than the jump width. Only one such adjustment happens per bit.

The whole configuration sits in one 32-bit word. That word can be changed only while the controller is held in reset mode, and in that mode the generator is parked and quiet.

Top module: `can_bit_timing`

## Requirements
- R1: After `rst`, `sample_stb` and `tx_stb` are 0, `rx_bit` is 1 (recessive) and `cfg_rdata` reads 0.
- R2: `cfg_wdata` is stored only on a clock where `cfg_we` and `reset_mode` are both 1; a write with `reset_mode` at 0 leaves `cfg_rdata` and the bit timing unchanged. Only the defined bits are kept: [9:0], [15:14], [19:16], [22:20] and [23]; all others read back 0, so an all-ones write reads back 0x00FFC3FF.
- R3: Field encodings, each stored as value minus one: prescaler P in [9:0], jump width J (1..4) in [15:14], first segment S1 (1..16) in [19:16], second segment S2 (1..8) in [22:20]; [23]=1 selects three-sample mode. With no bus edges, consecutive `sample_stb` pulses are P*(1+S1+S2) clocks apart.
- R4: `tx_stb` pulses when a bit begins. `sample_stb` pulses at the end of the first segment, P*(1+S1) clocks after the `tx_stb` of the same bit. The two pulses never coincide.
- R5: While `reset_mode` is 1 no strobe is produced. After it drops, the first quantum is the synchronisation quantum, so with P=1 the first `sample_stb` comes S1+1 clocks after release.
- R6: `rx_in` passes through a two-stage synchroniser. With `bus_idle`=1, a falling edge restarts the bit, and the quantum that showed the edge counts as its synchronisation quantum. With P=1, `rx_in` falling on clock k gives `sample_stb` on clock k+2+S1.
- R7: A falling edge seen in quantum k (0-based) of the first segment lengthens that segment by min(k+1, J).
- R8: A falling edge in the second segment with r quanta still to come, where r <= J, ends the bit at once. The edge quantum becomes the synchronisation quantum of the next bit, and `tx_stb` pulses.
- R9: A falling edge in the second segment with r > J shortens that segment by J.
- R10: In three-sample mode `rx_bit` takes the majority of the line values in the last three quanta of the first segment.
- R11: In single-sample mode `rx_bit` takes the line value of the last quantum of the first segment only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 1 | Controller held in reset mode: configuration writable, generator parked |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration word |
| bus_idle | input | 1 | Frame logic reports an idle bus, so edges hard-synchronise |
| rx_in | input | 1 | Asynchronous receive line, 1 = recessive |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| tx_stb | output | 1 | One-clock pulse at the start of a bit |
| rx_bit | output | 1 | Bit value taken at the last sample point |

## Verification
If the segment counter or its stretch and cut registers go wrong, the spacing of `sample_stb` and `tx_stb` shifts. That error shows within one bit time, and the checks count it in exact clocks. A bad edge detector or a stale previous-line value shows up as a hard or soft synchronisation that moves the next sample point by a known number of quanta, or that fails to move it. A fault in the majority history is visible only in `rx_bit` at the next sample point, so glitches are placed on exactly one of the three voting quanta.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // Width of the quantum counter inside a bit (16 + 4 stretch fits).
  localparam int Q_W     = 5;
  localparam int PRESC_W = 10;
  localparam int JW_W    = 2;
  localparam int S1_W    = 4;
  localparam int S2_W    = 3;

  // Bits of the configuration word that hold state.
  localparam logic [31:0] CFG_KEEP_MASK = 32'h00FF_C3FF;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  typedef struct packed {
    logic               vote3;
    logic [S2_W-1:0]    seg2_m1;
    logic [S1_W-1:0]    seg1_m1;
    logic [JW_W-1:0]    jump_m1;
    logic [PRESC_W-1:0] div_m1;
  } bt_cfg_t;

  function automatic bt_cfg_t split_cfg(input logic [31:0] w);
    bt_cfg_t c;
    c.div_m1  = w[9:0];
    c.jump_m1 = w[15:14];
    c.seg1_m1 = w[19:16];
    c.seg2_m1 = w[22:20];
    c.vote3   = w[23];
    return c;
  endfunction

endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg
  import cbt_pkg::*;
#(
  parameter logic [31:0] RESET_WORD = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reset_mode,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output bt_cfg_t     cfg
);

  logic [31:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= RESET_WORD & CFG_KEEP_MASK;
    end else if (we && reset_mode) begin
      word_q <= wdata & CFG_KEEP_MASK;
    end
  end

  assign rdata = word_q;
  assign cfg   = split_cfg(word_q);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !reset_mode |=> $stable(word_q)); // R2

endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] div_m1,
  output logic             tq_tick
);

  logic [CNT_W-1:0] cnt_q;

  assign tq_tick = run && (cnt_q == div_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tq_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && (div_m1 != '0)) |=> !tq_tick); // R3

endmodule

// File: rtl/cbt_rx_sampler.sv
module cbt_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tq_tick,
  input  logic vote3,
  input  logic rx_in,
  output logic rx_now,
  output logic rx_vote,
  output logic fall_edge
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [1:0]             hist_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b1;
        else     sync_q <= rx_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      end
    end
  endgenerate

  assign rx_now    = sync_q[SYNC_STAGES-1];
  assign fall_edge = tq_tick && prev_q && !rx_now;

  // Majority over the two previous quanta and the current one.
  assign rx_vote = vote3 ? ((hist_q[1] & hist_q[0]) | (hist_q[1] & rx_now) |
                            (hist_q[0] & rx_now))
                         : rx_now;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      prev_q <= 1'b1;
      hist_q <= 2'b11;
    end else if (tq_tick) begin
      prev_q <= rx_now;
      hist_q <= {hist_q[0], rx_now};
    end
  end

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    fall_edge |-> (run && !rx_now)); // R6

endmodule

// File: rtl/cbt_bit_seq.sv
module cbt_bit_seq
  import cbt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run,
  input  logic    tq_tick,
  input  logic    bus_idle,
  input  logic    fall_edge,
  input  logic    rx_vote,
  input  bt_cfg_t cfg,
  output logic    sample_stb,
  output logic    tx_stb,
  output logic    rx_bit
);

  seg_e           seg_q;
  logic [Q_W-1:0] qcnt_q;
  logic [2:0]     stretch_q;
  logic [2:0]     cut_q;
  logic           adjusted_q;

  logic [Q_W-1:0] seg1_len, seg2_len, late_err, remain, one_last, two_last;
  logic [2:0]     jump_len, stretch_new;
  logic           soft_edge;

  always_comb begin
    seg1_len    = Q_W'(cfg.seg1_m1) + Q_W'(1);
    seg2_len    = Q_W'(cfg.seg2_m1) + Q_W'(1);
    jump_len    = {1'b0, cfg.jump_m1} + 3'd1;
    late_err    = qcnt_q + Q_W'(1);
    stretch_new = (late_err > Q_W'(jump_len)) ? jump_len : late_err[2:0];
    remain      = seg2_len - Q_W'(1) - qcnt_q;
    one_last    = seg1_len + Q_W'(stretch_q) - Q_W'(1);
    two_last    = seg2_len - Q_W'(1) - Q_W'(cut_q);
    soft_edge   = fall_edge && !bus_idle && !adjusted_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q      <= SEG_SYNC;
      qcnt_q     <= '0;
      stretch_q  <= '0;
      cut_q      <= '0;
      adjusted_q <= 1'b0;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      rx_bit     <= 1'b1;
    end else begin
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      if (!run) begin
        seg_q      <= SEG_SYNC;
        qcnt_q     <= '0;
        stretch_q  <= '0;
        cut_q      <= '0;
        adjusted_q <= 1'b0;
      end else if (tq_tick) begin
        if (fall_edge && bus_idle) begin
          // Hard sync: the edge quantum was the sync quantum.
          seg_q      <= SEG_ONE;
          qcnt_q     <= '0;
          stretch_q  <= '0;
          cut_q      <= '0;
          adjusted_q <= 1'b0;
          tx_stb     <= 1'b1;
        end else begin
          unique case (seg_q)
            SEG_SYNC: begin
              seg_q      <= SEG_ONE;
              qcnt_q     <= '0;
              stretch_q  <= '0;
              cut_q      <= '0;
              adjusted_q <= 1'b0;
            end
            SEG_ONE: begin
              if (soft_edge) begin
                stretch_q  <= stretch_new;
                adjusted_q <= 1'b1;
                qcnt_q     <= qcnt_q + Q_W'(1);
              end else if (qcnt_q == one_last) begin
                seg_q      <= SEG_TWO;
                qcnt_q     <= '0;
                sample_stb <= 1'b1;
                rx_bit     <= rx_vote;
              end else begin
                qcnt_q <= qcnt_q + Q_W'(1);
              end
            end
            SEG_TWO: begin
              if (soft_edge && (remain <= Q_W'(jump_len))) begin
                seg_q      <= SEG_ONE;
                qcnt_q     <= '0;
                stretch_q  <= '0;
                cut_q      <= '0;
                adjusted_q <= 1'b0;
                tx_stb     <= 1'b1;
              end else if (soft_edge) begin
                cut_q      <= jump_len;
                adjusted_q <= 1'b1;
                qcnt_q     <= qcnt_q + Q_W'(1);
              end else if (qcnt_q == two_last) begin
                seg_q  <= SEG_SYNC;
                qcnt_q <= '0;
                tx_stb <= 1'b1;
              end else begin
                qcnt_q <= qcnt_q + Q_W'(1);
              end
            end
            default: begin
              seg_q  <= SEG_SYNC;
              qcnt_q <= '0;
            end
          endcase
        end
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && tx_stb)); // R4
  AST_SAMPLE_POS: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (seg_q == SEG_TWO && qcnt_q == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sample_stb && !tx_stb)); // R5
  AST_ONE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_ONE) |-> (qcnt_q < seg1_len + Q_W'(jump_len))); // R7
  AST_TWO_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_TWO) |-> (qcnt_q < seg2_len)); // R9

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RESET_WORD  = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reset_mode,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        bus_idle,
  input  logic        rx_in,
  output logic        sample_stb,
  output logic        tx_stb,
  output logic        rx_bit
);

  bt_cfg_t cfg;
  logic    run, tq_tick, rx_now, rx_vote, fall_edge;

  assign run = !reset_mode;

  cbt_cfg_reg #(.RESET_WORD(RESET_WORD)) cfg_i (
    .clk(clk), .rst(rst), .reset_mode(reset_mode),
    .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  cbt_tq_prescaler #(.CNT_W(PRESC_W)) presc_i (
    .clk(clk), .rst(rst), .run(run), .div_m1(cfg.div_m1), .tq_tick(tq_tick)
  );

  cbt_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) rxs_i (
    .clk(clk), .rst(rst), .run(run), .tq_tick(tq_tick), .vote3(cfg.vote3),
    .rx_in(rx_in), .rx_now(rx_now), .rx_vote(rx_vote), .fall_edge(fall_edge)
  );

  cbt_bit_seq seq_i (
    .clk(clk), .rst(rst), .run(run), .tq_tick(tq_tick), .bus_idle(bus_idle),
    .fall_edge(fall_edge), .rx_vote(rx_vote), .cfg(cfg),
    .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
  );

  logic unused_rx_now;
  assign unused_rx_now = rx_now;

endmodule

// File: tb/can_bit_timing_tb_top.sv
module can_bit_timing_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_mode = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_idle = 1'b0;
  logic        rx_in = 1'b1;
  logic        sample_stb, tx_stb, rx_bit;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timing dut_i (
    .clk(clk), .rst(rst), .reset_mode(reset_mode), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_idle(bus_idle),
    .rx_in(rx_in), .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
  );

  // Columns: prescaler, seg1, seg2, expected bit period in clocks.
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{1, 1, 1, 3}, '{2, 3, 2, 12}, '{4, 5, 3, 36},
    '{3, 16, 1, 54}, '{64, 16, 8, 1600}, '{5, 2, 8, 55}
  };

  function automatic logic [31:0] mk(int p, int j, int s1, int s2, int v3);
    logic [31:0] w;
    w = 32'((p - 1) & 32'h3FF) | (32'((j - 1) & 3) << 14) |
        (32'((s1 - 1) & 15) << 16) | (32'((s2 - 1) & 7) << 20) |
        (32'(v3 & 1) << 23);
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wait_pulse(input bit want_tx, output int at);
    at = -1;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (want_tx ? tx_stb : sample_stb) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    reset_mode = 1'b1;
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic park();
    @(negedge clk);
    reset_mode = 1'b1;
    rx_in = 1'b1;
    bus_idle = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, c0, strobes;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sample_stb", int'(sample_stb), 0);
    check("R1 tx_stb", int'(tx_stb), 0);
    check("R1 rx_bit", int'(rx_bit), 1);
    check("R1 cfg_rdata", int'(cfg_rdata), 0);
    rst = 1'b0;

    // R2 unused bits read zero
    write_cfg(32'hFFFF_FFFF);
    check("R2 mask", int'(cfg_rdata), int'(32'h00FF_C3FF));

    // R3/R4 table of bit periods
    for (int i = 0; i < NVEC; i++) begin
      write_cfg(mk(VEC[i][0], 1, VEC[i][1], VEC[i][2], 0));
      @(negedge clk);
      reset_mode = 1'b0;
      wait_pulse(1'b1, t0);
      wait_pulse(1'b0, t1);
      wait_pulse(1'b0, t2);
      check("R4 tx to sample", t1 - t0, VEC[i][0] * (1 + VEC[i][1]));
      check("R3 period", t2 - t1, VEC[i][3]);
      park();
    end

    // R5 quiet in reset mode
    strobes = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (sample_stb || tx_stb) strobes++;
    end
    check("R5 no strobes in reset mode", strobes, 0);

    // R2 write outside reset mode ignored
    write_cfg(mk(2, 1, 3, 2, 0));
    @(negedge clk);
    reset_mode = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = mk(7, 2, 9, 5, 1);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2 rdata kept", int'(cfg_rdata), int'(mk(2, 1, 3, 2, 0)));
    wait_pulse(1'b0, t1);
    wait_pulse(1'b0, t2);
    check("R2 period kept", t2 - t1, 12);
    park();

    // R5 start at sync quantum, R7 late edge stretch clamped by jump width
    for (int j = 1; j <= 4; j += 3) begin
      write_cfg(mk(1, j, 4, 4, 0));
      repeat (3) @(negedge clk);
      @(negedge clk);
      c0 = cyc;
      reset_mode = 1'b0;
      rx_in = 1'b0;
      wait_pulse(1'b0, t1);
      check("R7 late stretch", t1 - c0, (j == 1) ? 6 : 7);
      park();
    end

    // R5 first sample timing and R8 early edge inside jump width
    write_cfg(mk(1, 4, 4, 4, 0));
    repeat (3) @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    reset_mode = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b0;
    check("R5 first sample", int'(sample_stb), 0);
    wait_pulse(1'b0, t1);
    check("R5 first sample", t1 - c0, 5);
    wait_pulse(1'b0, t2);
    check("R8 early resync", t2 - c0, 11);
    park();

    // R9 early edge beyond jump width
    write_cfg(mk(1, 1, 4, 4, 0));
    repeat (3) @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    reset_mode = 1'b0;
    repeat (3) @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, t1);
    wait_pulse(1'b0, t2);
    check("R9 seg2 cut", t2 - c0, 13);
    park();

    // R6 hard sync
    write_cfg(mk(1, 1, 6, 2, 0));
    bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    reset_mode = 1'b0;
    rx_in = 1'b0;
    wait_pulse(1'b0, t1);
    check("R6 hard sync", t1 - c0, 9);
    park();

    // R10 / R11 glitch on the last voting quantum only
    for (int v = 0; v < 2; v++) begin
      write_cfg(mk(1, 1, 6, 2, v));
      bus_idle = 1'b1;
      repeat (3) @(negedge clk);
      @(negedge clk);
      reset_mode = 1'b0;
      rx_in = 1'b0;
      for (int k = 1; k <= 9; k++) begin
        @(negedge clk);
        if (k == 3) bus_idle = 1'b0;
        if (k == 6) rx_in = 1'b1;
        if (k == 7) rx_in = 1'b0;
      end
      check(v ? "R10 vote strobe" : "R11 single strobe", int'(sample_stb), 1);
      check(v ? "R10 majority" : "R11 single", int'(rx_bit), v ? 0 : 1);
      park();
    end

    finish_run();
  end

endmodule